// File: doc/BRIEF.md
# Shared Mailbox Interrupt Aggregator

This block gathers the "holds a message" and "has been drained" level indications of a set of shared mailboxes into one packed status word. Each mailbox slot owns one drained bit in the low byte and one holding bit in the high byte. Several shared interrupt lines each apply their own enable mask to that status word. A line is raised when any enabled status bit is set, and it stays raised for as long as the mailbox condition persists. The only way to drop a source is to clear the condition at the mailbox.

A small register port gives software read access to the status word, read/write access to one enable mask per line, and read access to a vector of the lines that are currently raised. The same port also returns a constant sizing word, so software can learn how many mailboxes, semaphores, doorbells and interrupt lines were built in. The number of mailboxes and the number of lines are parameters. Status and enable bits of slots that are not built always read zero.

Top module: `mbox_irq_agg`

## Requirements
- R1: Status word at offset 0x304: bit i is the drained input of mailbox i (empty_i[i]) and bit 8+i is its holding input (full_i[i]). The inputs are registered once, so a read issued one cycle after an input change returns the new value.
- R2: Status bits and enable bits belonging to mailbox slots at or above NUM_MBOX always read zero, including after a write of all ones.
- R3: Line n has an enable mask at offset 0x100 + 4*n for n < NUM_LINES. The mask has the same bit layout as the status word. A write updates it on the next edge, reads return it in bits 15:0 with bits 31:16 zero, and it holds its value when it is not written.
- R4: irq_o[n] is high exactly when (status AND mask n) is non-zero, sampled one edge after the status word. A mailbox input change therefore reaches irq_o two edges later.
- R5: The lines are level sensitive. An enabled source keeps its line high for as long as the input stays set, and the line falls two edges after the input clears.
- R6: A line whose mask is zero never goes high, whatever the status word holds.
- R7: Sizing word at offset 0x380: bits 3:0 give the mailbox count, bits 7:4 the shared semaphore count, bits 11:8 the arbitrated semaphore count, bits 15:12 the doorbell count, bits 19:16 the interrupt line count, and the other bits are zero.
- R8: Offset 0x300 reads a vector whose bit n equals the current irq_o[n].
- R9: Writes to 0x300, 0x304 and 0x380 change nothing. Reads of any unmapped offset, including masks for lines at or above NUM_LINES, return zero.
- R10: After reset, irq_o is zero, every mask is zero and rdata is zero. rdata changes only on an edge where rd_en is high, and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| empty_i | input | NUM_MBOX | Drained level per mailbox |
| full_i | input | NUM_MBOX | Holding level per mailbox |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 16 | Write data (masks are 16 bits wide) |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | NUM_LINES | Shared interrupt lines |

## Verification
The case that needs care is a mask write that lands on the same edge as a mailbox input change. Both reach the interrupt line in the next cycle, and neither can lag the other. The bench drives the enable write and the rising mailbox input in the same cycle, then checks that the line is high exactly two edges later. In a second step it clears the mask on the same edge as a new source rises, and checks that the line stays low.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int SLOTS    = 8;
  localparam int STAT_W   = 2 * SLOTS;
  localparam int FULL_LSB = SLOTS;

  localparam logic [11:0] OFF_PEND    = 12'h300;
  localparam logic [11:0] OFF_STAT    = 12'h304;
  localparam logic [11:0] OFF_DIM     = 12'h380;
  localparam logic [11:0] OFF_EN_BASE = 12'h100;

  // Mask of status/enable bits that exist for a given mailbox count
  function automatic logic [STAT_W-1:0] built_mask(input int nmbox);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i < nmbox) begin
        m[i]            = 1'b1;
        m[FULL_LSB + i] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/mbox_status_reg.sv
module mbox_status_reg
  import mbox_irq_pkg::*;
#(
  parameter int NUM_MBOX = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] empty_i,
  input  logic [NUM_MBOX-1:0] full_i,
  output logic [STAT_W-1:0]   status_q
);
  logic [STAT_W-1:0] packed_d;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_MBOX) begin : g_built
      assign packed_d[i]            = empty_i[i];
      assign packed_d[FULL_LSB + i] = full_i[i];
    end else begin : g_absent
      assign packed_d[i]            = 1'b0;
      assign packed_d[FULL_LSB + i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= packed_d;
  end

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[NUM_MBOX-1:0] == $past(empty_i)) &&
             (status_q[FULL_LSB+NUM_MBOX-1:FULL_LSB] == $past(full_i))); // R1
endmodule

// File: rtl/mbox_irq_line.sv
module mbox_irq_line
  import mbox_irq_pkg::*;
#(
  parameter int LINE_IDX = 0,
  parameter int NUM_MBOX = 8,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] en_q,
  output logic              irq_q
);
  localparam logic [ADDR_W-1:0] MY_OFF  = ADDR_W'(OFF_EN_BASE) + ADDR_W'(4 * LINE_IDX);
  localparam logic [STAT_W-1:0] WR_MASK = built_mask(NUM_MBOX);

  logic hit;
  assign hit = wr_en && (addr == MY_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (hit) en_q <= wdata & WR_MASK;
      irq_q <= |(status_i & en_q);
    end
  end

  AST_ZERO_EN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_q); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(en_q)); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past((status_i & en_q) != '0)); // R4
endmodule

// File: rtl/mbox_reg_read.sv
module mbox_reg_read
  import mbox_irq_pkg::*;
#(
  parameter int          NUM_LINES = 4,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [19:0] DIM_VALUE = 20'h0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [STAT_W-1:0]           status_i,
  input  logic [NUM_LINES*STAT_W-1:0] en_flat,
  input  logic [NUM_LINES-1:0]        pend_i,
  output logic [DATA_W-1:0]           rdata_q
);
  logic [DATA_W-1:0] rd_mux;
  logic              mapped;

  always_comb begin
    rd_mux = '0;
    mapped = 1'b0;
    if (addr == ADDR_W'(OFF_PEND)) begin
      rd_mux = DATA_W'(pend_i);
      mapped = 1'b1;
    end else if (addr == ADDR_W'(OFF_STAT)) begin
      rd_mux = DATA_W'(status_i);
      mapped = 1'b1;
    end else if (addr == ADDR_W'(OFF_DIM)) begin
      rd_mux = DATA_W'(DIM_VALUE);
      mapped = 1'b1;
    end else begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if (addr == ADDR_W'(OFF_EN_BASE) + ADDR_W'(4 * n)) begin
          rd_mux = DATA_W'(en_flat[n*STAT_W +: STAT_W]);
          mapped = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata_q == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/mbox_irq_agg.sv
module mbox_irq_agg
  import mbox_irq_pkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int NUM_LINES = 4,
  parameter int NUM_SSEM  = 4,
  parameter int NUM_ASEM  = 2,
  parameter int NUM_DBELL = 7,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MBOX-1:0]  empty_i,
  input  logic [NUM_MBOX-1:0]  full_i,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [STAT_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam logic [19:0] DIM_VALUE = {4'(NUM_LINES), 4'(NUM_DBELL), 4'(NUM_ASEM),
                                       4'(NUM_SSEM), 4'(NUM_MBOX)};

  logic [STAT_W-1:0]           status_q;
  logic [NUM_LINES*STAT_W-1:0] en_flat;

  mbox_status_reg #(.NUM_MBOX(NUM_MBOX)) u_status (
    .clk      (clk),
    .rst      (rst),
    .empty_i  (empty_i),
    .full_i   (full_i),
    .status_q (status_q)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    mbox_irq_line #(
      .LINE_IDX (n),
      .NUM_MBOX (NUM_MBOX),
      .ADDR_W   (ADDR_W)
    ) u_line (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .status_i (status_q),
      .en_q     (en_flat[n*STAT_W +: STAT_W]),
      .irq_q    (irq_o[n])
    );
  end

  mbox_reg_read #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DIM_VALUE (DIM_VALUE)
  ) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .status_i (status_q),
    .en_flat  (en_flat),
    .pend_i   (irq_o),
    .rdata_q  (rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_o == '0) && (rdata == '0)); // R10
endmodule

// File: tb/tb_mbox_irq_agg.sv
`timescale 1ns/1ps
module tb_mbox_irq_agg;
  localparam int NM = 6;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] empty_i = '0;
  logic [NM-1:0] full_i = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [15:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NL-1:0] irq_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mbox_irq_agg #(.NUM_MBOX(NM), .NUM_LINES(NL), .NUM_SSEM(4), .NUM_ASEM(2),
                 .NUM_DBELL(7)) dut (
    .clk(clk), .rst(rst), .empty_i(empty_i), .full_i(full_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [NM-1:0] e;
    logic [NM-1:0] f;
    logic [15:0]   en0;
    logic [15:0]   en1;
    logic [15:0]   en2;
    logic [NL-1:0] irq;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{e:6'h01, f:6'h00, en0:16'h0001, en1:16'h0100, en2:16'h0000, irq:3'b001},
    '{e:6'h00, f:6'h20, en0:16'h0001, en1:16'h2000, en2:16'hFFFF, irq:3'b110},
    '{e:6'h3F, f:6'h3F, en0:16'h0000, en1:16'h0000, en2:16'h0000, irq:3'b000},
    '{e:6'h02, f:6'h04, en0:16'h0400, en1:16'h0001, en2:16'h0002, irq:3'b101}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] stat_of(input logic [NM-1:0] e, input logic [NM-1:0] f);
    return (32'(f) << 8) | 32'(e);
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 irq after reset", 32'(irq_o), 32'h0);
    check("R10 rdata after reset", rdata, 32'h0);
    rst = 1'b0;
    do_read(12'h100, d); check("R10 mask0 reset", d, 32'h0);
    do_read(12'h304, d); check("R1 status idle", d, 32'h0);

    // table walk
    foreach (VECS[i]) begin
      do_write(12'h100, VECS[i].en0);
      do_write(12'h104, VECS[i].en1);
      do_write(12'h108, VECS[i].en2);
      @(negedge clk);
      empty_i = VECS[i].e; full_i = VECS[i].f;
      repeat (2) @(negedge clk);
      check($sformatf("R4 irq vector %0d", i), 32'(irq_o), 32'(VECS[i].irq));
      do_read(12'h304, d);
      check($sformatf("R1 status vector %0d", i), d, stat_of(VECS[i].e, VECS[i].f));
      do_read(12'h300, d);
      check($sformatf("R8 pending vector %0d", i), d, 32'(VECS[i].irq));
    end

    // R2 / R3: unbuilt bits of mask read zero
    do_read(12'h108, d); check("R2 R3 mask2 readback", d, 32'h0000_0002);
    do_write(12'h108, 16'hFFFF);
    do_read(12'h108, d); check("R2 mask unbuilt bits", d, 32'h0000_3F3F);
    do_read(12'h104, d); check("R3 mask1 held", d, 32'h0000_0001);

    // R7 sizing word
    do_read(12'h380, d); check("R7 sizing", d, 32'h0003_7246);

    // R9 writes to read-only offsets ignored, unmapped reads zero
    do_write(12'h380, 16'h0000);
    do_read(12'h380, d); check("R9 sizing write ignored", d, 32'h0003_7246);
    do_write(12'h304, 16'h0000);
    do_read(12'h304, d); check("R9 status write ignored", d, stat_of(6'h02, 6'h04));
    do_write(12'h300, 16'h0000);
    do_read(12'h300, d); check("R9 pending write ignored", d, 32'(irq_o));
    do_write(12'h10C, 16'hFFFF);
    do_read(12'h10C, d); check("R9 absent line mask", d, 32'h0);
    do_read(12'h200, d); check("R9 unmapped", d, 32'h0);

    // R10 rdata holds without rd_en
    held = rdata;
    repeat (3) @(negedge clk);
    check("R10 rdata hold", rdata, held);

    // R6 zero mask silences everything
    do_write(12'h100, 16'h0000); do_write(12'h104, 16'h0000); do_write(12'h108, 16'h0000);
    @(negedge clk); empty_i = '1; full_i = '1;
    repeat (4) @(negedge clk);
    check("R6 all masks zero", 32'(irq_o), 32'h0);

    // R5 level behaviour
    @(negedge clk); empty_i = '0; full_i = '0;
    do_write(12'h104, 16'h0800);  // holding bit of mailbox 3 on line 1
    @(negedge clk); full_i = 6'h08;
    repeat (10) @(negedge clk);
    check("R5 line held while set", 32'(irq_o), 32'b010);
    @(negedge clk); full_i = 6'h00;
    @(negedge clk);
    check("R5 line still high one edge after clear", 32'(irq_o), 32'b010);
    @(negedge clk);
    check("R5 line low two edges after clear", 32'(irq_o), 32'b000);

    // same-cycle: mask write and source rise together
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h100; wdata = 16'h0004; empty_i = 6'h04;
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 same-cycle one edge", 32'(irq_o), 32'b000);
    @(negedge clk);
    check("R4 same-cycle two edges", 32'(irq_o), 32'b001);
    // clear mask on the same edge a second source rises
    wr_en = 1'b1; addr = 12'h100; wdata = 16'h0000; empty_i = 6'h05;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R6 cleared mask with new source", 32'(irq_o), 32'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule